// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

A 16-bit up-counting timer with a register interface of four locations. A control register sets the run bit, the count-clock source, an 8-bit prescaler, the restart-on-match behaviour and the interrupt enable. A reference register sets the compare value and a counter register holds the live count. An event register holds a sticky match flag. The count clock is the system clock, or the system clock divided by sixteen, in both cases divided again by the prescale field plus one.

Each count tick either advances the counter or, when the counter already equals the reference, marks a match. With restart selected, a match returns the counter to zero, so one period spans reference plus one ticks. A match sets the sticky flag, and software clears it by writing a one. The single interrupt output is high while the flag is set and the interrupt enable bit is set. Software reads the counter directly as the ticks elapsed in the current period. Clearing the run bit while the timer runs stops it and resets its counting state.

Top module: `prescaled_ref_timer`

## Requirements
- R1: After reset the control register reads 0, the reference reads 0xFFFF, the counter reads 0, the event register reads 0 and `irq` is low.
- R2: Control bits [2:1] pick the count source. Code 1 takes every system clock, code 2 takes one system clock in 16, and codes 0 and 3 stop counting without clearing the counter.
- R3: Control bits [15:8] hold a prescale value P. A count tick occurs once every P+1 source pulses, starting from the write that sets the run bit.
- R4: With control bit 3 set, a tick that finds the counter equal to the reference loads the counter with 0. Any other tick adds one to the counter.
- R5: A tick that finds the counter equal to the reference sets the match flag, which reads as bit 1 at event offset 0x11.
- R6: Writing the event register with bit 1 set clears the match flag. Writing it with bit 1 clear leaves the flag unchanged.
- R7: `irq` is high exactly when control bit 4 (interrupt enable) and the match flag are both set. A write to either one shows on `irq` from the clock edge of that write.
- R8: While control bit 0 (run) is 0 the counter does not change. A control write that clears bit 0 while it was 1 clears the counter, the match flag and the prescale state.
- R9: A write to counter offset 0x0C loads the counter, and a read of that offset returns the current count.
- R10: With control bit 3 clear, a match still sets the flag but the counter keeps counting past the reference.
- R11: The registers sit at offsets 0x00 (control), 0x04 (reference), 0x0C (counter) and 0x11 (event). Control bits [7:5] read as 0. Other offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 5 | Register byte offset |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt: enable AND match flag |

## Verification
The hardest state to reach from the ports is a match flag that is set while counting has stopped and the counter is left unreset. Only there can clear-on-one, write-zero-has-no-effect and interrupt gating be checked without a new match racing the check. The bench lets a free-running count pass the reference with the interrupt disabled. It then rewrites the control register to a stopped source code while the run bit stays set, which freezes the counter but does not reset it. After that it changes the enable and the event register one write at a time. A table of source, prescale, reference and wait values covers the periods, and the bench computes each expected count and flag from the divide ratios.

// File: rtl/prescaled_ref_timer.sv
module prescaled_ref_timer #(
  parameter int CNT_W     = 16,
  parameter int PRE_W     = 8,
  parameter int SLOW_LOG2 = 4,
  parameter int ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_REF  = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(5'h11);
  localparam int PAD_W = CNT_W - PRE_W - 5;

  logic                 run_q, reload_q, ie_q, flag_q;
  logic [1:0]           src_q;
  logic [PRE_W-1:0]     presc_q, pre_q;
  logic [SLOW_LOG2-1:0] div_q;
  logic [CNT_W-1:0]     ref_q, cnt_q;

  wire ctrl_wr = wr_en && addr == A_CTRL;
  wire ref_wr  = wr_en && addr == A_REF;
  wire cnt_wr  = wr_en && addr == A_CNT;
  wire evt_wr  = wr_en && addr == A_EVT;
  wire stop_wr = ctrl_wr && run_q && !wr_data[0];
  wire slow_en = &div_q;
  wire src_en  = run_q && (src_q == 2'd1 || (src_q == 2'd2 && slow_en));
  wire tick    = src_en && pre_q == presc_q;
  wire match   = tick && cnt_q == ref_q;

  assign irq = ie_q && flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      src_q    <= 2'd0;
      reload_q <= 1'b0;
      ie_q     <= 1'b0;
      presc_q  <= '0;
    end else if (ctrl_wr) begin
      run_q    <= wr_data[0];
      src_q    <= wr_data[2:1];
      reload_q <= wr_data[3];
      ie_q     <= wr_data[4];
      presc_q  <= wr_data[PRE_W+7:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ref_q <= '1;
    else if (ref_wr) ref_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_q || stop_wr || src_q != 2'd2) div_q <= '0;
    else                                              div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_q || stop_wr) pre_q <= '0;
    else if (src_en)                 pre_q <= tick ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stop_wr) cnt_q <= '0;
    else if (cnt_wr)       cnt_q <= wr_data;
    else if (tick)         cnt_q <= (match && reload_q) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stop_wr)        flag_q <= 1'b0;
    else if (match)               flag_q <= 1'b1;
    else if (evt_wr && wr_data[1]) flag_q <= 1'b0;
  end

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = {{PAD_W{1'b0}}, presc_q, 3'b000, ie_q, reload_q, src_q, run_q};
      A_REF:   rd_data = ref_q;
      A_CNT:   rd_data = cnt_q;
      A_EVT:   rd_data = {{(CNT_W-2){1'b0}}, flag_q, 1'b0};
      default: rd_data = '0;
    endcase
  end
endmodule

module prescaled_ref_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             ctrl_wr,
  input logic             evt_wr,
  input logic             bit0,
  input logic             bit1,
  input logic             run_q,
  input logic             ie_q,
  input logic             reload_q,
  input logic             flag_q,
  input logic             tick,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] ref_q
);
  p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_en) |=> $stable(cnt_q));

  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && run_q && !bit0) |=> (cnt_q == '0 && !flag_q));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && cnt_q != ref_q) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && reload_q && cnt_q == ref_q) |=> (cnt_q == '0 && flag_q));

  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wr && bit1 && !tick) |=> !flag_q);

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !irq);
endmodule

bind prescaled_ref_timer prescaled_ref_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctrl_wr(ctrl_wr), .evt_wr(evt_wr),
  .bit0(wr_data[0]), .bit1(wr_data[1]), .run_q(run_q), .ie_q(ie_q),
  .reload_q(reload_q), .flag_q(flag_q), .tick(tick), .irq(irq),
  .cnt_q(cnt_q), .ref_q(ref_q)
);

// File: tb/prescaled_ref_timer_tb.sv
module prescaled_ref_timer_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 10;
  // {source code, prescale, reference, cycles to wait}
  localparam int VEC [NV][4] = '{
    '{1, 0, 3, 2},   '{1, 0, 3, 4},   '{1, 0, 3, 9},   '{1, 2, 5, 7},
    '{1, 2, 5, 20},  '{2, 0, 2, 40},  '{2, 1, 1, 70},  '{1, 255, 0, 200},
    '{1, 255, 0, 300}, '{2, 0, 0, 15}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;
  int checks = 0;
  int fails = 0;

  prescaled_ref_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] ctl(int run, int src, int rl, int ie, int p);
    return {p[7:0], 3'b000, ie[0], rl[0], src[1:0], run[0]};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] v, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(5'h00, v); chk("R1 control", v, 16'h0000);
    rd(5'h04, v); chk("R1 reference", v, 16'hFFFF);
    rd(5'h0C, v); chk("R1 counter", v, 16'h0000);
    rd(5'h11, v); chk("R1 event", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // R2 R3 R4 R5 R7: table of periods
    for (int i = 0; i < NV; i++) begin
      int dv, t, ec, ef;
      dv = (VEC[i][0] == 2 ? 16 : 1) * (VEC[i][1] + 1);
      t  = VEC[i][3] / dv;
      ec = t % (VEC[i][2] + 1);
      ef = (t >= VEC[i][2] + 1) ? 1 : 0;
      wr(5'h00, 16'h0000);
      wr(5'h04, 16'(VEC[i][2]));
      wr(5'h00, ctl(1, VEC[i][0], 1, 1, VEC[i][1]));
      wait_cyc(VEC[i][3]);
      rd(5'h0C, v); chk("R2 R3 R4 count", v, 16'(ec));
      rd(5'h11, v); chk("R5 flag", v, 16'(ef * 2));
      chk("R7 irq", {15'd0, irq}, 16'(ef));
    end

    // R8 disable while running clears and holds
    wr(5'h00, 16'h0000);
    wr(5'h04, 16'd100);
    wr(5'h00, ctl(1, 1, 1, 1, 0));
    wait_cyc(7);
    rd(5'h0C, v); chk("R9 count read", v, 16'd7);
    wr(5'h00, 16'h0000);
    rd(5'h0C, v); chk("R8 cleared", v, 16'd0);
    wait_cyc(5);
    rd(5'h0C, v); chk("R8 held", v, 16'd0);

    // R10 no restart: counts past reference, flag set, irq gated off
    wr(5'h04, 16'd3);
    wr(5'h00, ctl(1, 1, 0, 0, 0));
    wait_cyc(6);
    rd(5'h0C, v); chk("R10 past ref", v, 16'd6);
    rd(5'h11, v); chk("R10 flag", v, 16'h0002);
    chk("R7 irq gated", {15'd0, irq}, 16'h0000);

    // R2 code 0 stops without reset, R7 enable raises irq
    wr(5'h00, ctl(1, 0, 0, 1, 0));
    chk("R7 irq on enable", {15'd0, irq}, 16'h0001);
    rd(5'h0C, v); chk("R2 stop code 0", v, 16'd7);
    wait_cyc(5);
    rd(5'h0C, v); chk("R2 stop code 0 held", v, 16'd7);

    // R6 write-one-to-clear
    wr(5'h11, 16'h0000);
    rd(5'h11, v); chk("R6 zero write", v, 16'h0002);
    wr(5'h11, 16'h0002);
    rd(5'h11, v); chk("R6 clear", v, 16'h0000);
    chk("R7 irq after clear", {15'd0, irq}, 16'h0000);

    // R9 load counter, then R4 match from loaded value
    wr(5'h0C, 16'h1234);
    rd(5'h0C, v); chk("R9 load", v, 16'h1234);
    wr(5'h04, 16'h1236);
    wr(5'h00, ctl(1, 1, 1, 1, 0));
    wait_cyc(2);
    rd(5'h0C, v); chk("R9 count from load", v, 16'h1236);
    wait_cyc(1);
    rd(5'h0C, v); chk("R4 restart", v, 16'h0000);
    rd(5'h11, v); chk("R5 flag at match", v, 16'h0002);

    // R2 code 3 stops counting
    wr(5'h00, ctl(1, 3, 1, 1, 0));
    rd(5'h0C, c0);
    wait_cyc(20);
    rd(5'h0C, v); chk("R2 stop code 3", v, c0);

    // R11 register map
    wr(5'h00, 16'hA5FB);
    rd(5'h00, v); chk("R11 control readback", v, 16'hA51B);
    wr(5'h08, 16'h5555);
    rd(5'h08, v); chk("R11 unmapped read", v, 16'h0000);
    rd(5'h04, v); chk("R11 reference kept", v, 16'h1236);

    summary();
  end
endmodule